// File: doc/BRIEF.md
# 8b/10b Lane Synchronization State Machine

This block watches a stream of aligned 10-bit code groups coming out of an 8b/10b decoder and decides, on its own, whether the serial lane is synchronized. The upstream logic supplies one code group per cycle with a valid strobe, a comma-detect flag and a code-error flag. The code-error flag covers both an invalid code and a running-disparity error. No outside control is needed to acquire or drop synchronization.

In the hunt phase, the block counts K28.5 commas in either disparity form. Once enough clean commas have arrived, it declares the lane locked. While locked, every bad code group raises an error count, and long runs of clean code groups lower it again. The lane is dropped when the count reaches a limit. This hysteresis keeps rare isolated errors from tearing down a working link. The comma threshold, the error limit and the run length that earns one decrement are parameters, with defaults of 127, 3 and 255.

Top module: `lane_sync_fsm`

## Requirements
- R1: A qualifying comma is a valid, error-free code group with the comma flag set whose 10 bits equal 10'b0011111010 or 10'b1100000101. Either form counts, and a flagged group with any other value does not.
- R2: While hunting, the lock flag rises on the cycle after the clock edge that samples the ACQ_COUNT-th qualifying comma (default 127). Valid, error-free non-comma groups leave the comma tally unchanged.
- R3: While hunting, any valid group with the error flag set returns the comma tally to zero, so a full ACQ_COUNT fresh commas are needed afterwards.
- R4: While locked, each valid group with the error flag set raises the error count by one. The LOSS_COUNT-th error (default 3) drops the lock, clears the error count and restarts the hunt from a zero comma tally.
- R5: While locked with a nonzero error count, every GOOD_RUN consecutive valid error-free groups (default 255) lower the error count by one. The run restarts from zero after any error and after each decrement, and the count never goes below zero.
- R6: A cycle with the valid strobe low changes no counter and no output.
- R7: A synchronous active-high reset forces the lock flag low, the error count to zero and the state to hunting.
- R8: The state output reads 2'b00 while hunting, 2'b01 when locked with a zero error count, and 2'b10 when locked with a nonzero error count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cg_valid | input | 1 | Code group on this cycle is to be evaluated |
| cg_data | input | 10 | Aligned 10-bit code group |
| cg_comma | input | 1 | Upstream comma detection for this group |
| cg_err | input | 1 | Invalid code or disparity error for this group |
| locked | output | 1 | Lane synchronized |
| state | output | 2 | Current state (R8 encoding) |
| err_cnt | output | EW | Current error count, EW = $clog2(LOSS_COUNT+1) |

## Verification
The comma tally and the good-run counter are not visible at the ports. A wrong value in either one shows up only later, as the lock rising or the error count falling on the wrong cycle. The bench therefore compares the lock flag, state and error count on every cycle against a reference model. It uses short thresholds, so a miscount surfaces within a few groups instead of hundreds. An off-by-one in the comma tally shows up one comma early or late. A run counter that fails to restart after an error shows up as an early decrement. A broken loss path shows up as a lane that stays locked after the limit is reached.

// File: rtl/lane_sync_fsm.sv
module lane_sync_fsm #(
  parameter int ACQ_COUNT  = 127,
  parameter int LOSS_COUNT = 3,
  parameter int GOOD_RUN   = 255,
  localparam int CW = $clog2(ACQ_COUNT + 1),
  localparam int EW = $clog2(LOSS_COUNT + 1),
  localparam int GW = $clog2(GOOD_RUN + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cg_valid,
  input  logic [9:0]    cg_data,
  input  logic          cg_comma,
  input  logic          cg_err,
  output logic          locked,
  output logic [1:0]    state,
  output logic [EW-1:0] err_cnt
);

  logic [CW-1:0] comma_tally;
  logic [GW-1:0] run_len;

  wire is_k285   = (cg_data == 10'b0011111010) || (cg_data == 10'b1100000101);
  wire bad_grp   = cg_valid && cg_err;
  wire good_grp  = cg_valid && !cg_err;
  wire comma_hit = good_grp && cg_comma && is_k285;

  always_ff @(posedge clk) begin
    if (rst) begin
      locked      <= 1'b0;
      err_cnt     <= '0;
      comma_tally <= '0;
      run_len     <= '0;
    end else if (!locked) begin
      if (bad_grp) begin
        comma_tally <= '0;
      end else if (comma_hit) begin
        if (comma_tally == CW'(ACQ_COUNT - 1)) begin
          locked      <= 1'b1;
          comma_tally <= '0;
        end else begin
          comma_tally <= comma_tally + 1'b1;
        end
      end
    end else if (bad_grp) begin
      run_len <= '0;
      if (err_cnt == EW'(LOSS_COUNT - 1)) begin
        locked  <= 1'b0;
        err_cnt <= '0;
      end else begin
        err_cnt <= err_cnt + 1'b1;
      end
    end else if (good_grp && err_cnt != '0) begin
      if (run_len == GW'(GOOD_RUN - 1)) begin
        run_len <= '0;
        err_cnt <= err_cnt - 1'b1;
      end else begin
        run_len <= run_len + 1'b1;
      end
    end
  end

  assign state = !locked ? 2'b00 : (err_cnt == '0 ? 2'b01 : 2'b10);

  assert_lock_on_comma_R2: assert property (@(posedge clk) disable iff (rst)
    ($rose(locked) && !$past(rst)) |-> $past(comma_hit));

  assert_err_below_limit_R4: assert property (@(posedge clk) disable iff (rst)
    err_cnt < EW'(LOSS_COUNT));

  assert_drop_on_error_R4: assert property (@(posedge clk) disable iff (rst)
    ($fell(locked) && !$past(rst)) |-> $past(bad_grp));

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !cg_valid |=> ($stable(locked) && $stable(err_cnt)));

  assert_hunt_no_errors_R8: assert property (@(posedge clk) disable iff (rst)
    !locked |-> (err_cnt == '0 && state == 2'b00));

endmodule

// File: tb/lane_sync_fsm_bench.sv
module lane_sync_fsm_bench;
  localparam int ACQ = 5, LOSS = 3, RUN = 4, EW = $clog2(LOSS + 1);
  localparam logic [9:0] KNEG = 10'b0011111010, KPOS = 10'b1100000101;

  logic clk = 0, rst = 1, cg_valid = 0, cg_comma = 0, cg_err = 0;
  logic [9:0] cg_data = '0;
  logic locked;
  logic [1:0] state;
  logic [EW-1:0] err_cnt;
  int checks = 0, errors = 0;
  int m_lock, m_cc, m_ec, m_run;

  always #4 clk = ~clk;

  lane_sync_fsm #(.ACQ_COUNT(ACQ), .LOSS_COUNT(LOSS), .GOOD_RUN(RUN)) u_lane_sync_fsm (
    .clk(clk), .rst(rst), .cg_valid(cg_valid), .cg_data(cg_data),
    .cg_comma(cg_comma), .cg_err(cg_err), .locked(locked), .state(state), .err_cnt(err_cnt));

  function automatic logic [1:0] exp_state(int lk, int ec);
    return lk == 0 ? 2'b00 : (ec == 0 ? 2'b01 : 2'b10);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model(logic v, logic [9:0] d, logic cm, logic er);
    bit hit = v && !er && cm && (d == KNEG || d == KPOS);
    if (!v) return;
    if (m_lock == 0) begin
      if (er) m_cc = 0;
      else if (hit) begin
        m_cc++;
        if (m_cc == ACQ) begin m_lock = 1; m_cc = 0; end
      end
    end else if (er) begin
      m_run = 0; m_ec++;
      if (m_ec == LOSS) begin m_lock = 0; m_ec = 0; end
    end else if (m_ec != 0) begin
      m_run++;
      if (m_run == RUN) begin m_run = 0; m_ec--; end
    end
  endtask

  task automatic step(logic v, logic [9:0] d, logic cm, logic er, string req);
    cg_valid = v; cg_data = d; cg_comma = cm; cg_err = er;
    @(posedge clk);
    model(v, d, cm, er);
    #2;
    check({req, " locked"}, locked, m_lock);
    check({req, " err_cnt"}, err_cnt, m_ec);
    check({req, " state"}, state, exp_state(m_lock, m_ec));
    @(negedge clk);
  endtask

  task automatic comma(logic [9:0] d, string req); step(1, d, 1, 0, req); endtask
  task automatic good(string req); step(1, 10'h2AA, 0, 0, req); endtask
  task automatic bad(string req); step(1, 10'h155, 0, 1, req); endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_lock = 0; m_cc = 0; m_ec = 0; m_run = 0;
    @(negedge clk); @(negedge clk);
    rst = 0;
    // R7 reset state
    check("R7 locked", locked, 0);
    check("R7 err_cnt", err_cnt, 0);
    check("R7 state", state, 0);
    // R1 flagged non-K28.5 does not count; both disparity forms do
    step(1, 10'h17C, 1, 0, "R1");
    comma(KNEG, "R1"); comma(KPOS, "R1"); good("R2"); comma(KNEG, "R1");
    // R3 error in hunt resets tally
    bad("R3");
    comma(KPOS, "R3"); comma(KNEG, "R3"); comma(KPOS, "R3"); comma(KNEG, "R3");
    check("R3 still hunting", locked, 0);
    // R6 idle holds
    step(0, KNEG, 1, 0, "R6");
    comma(KPOS, "R2");
    check("R2 locked after ACQ commas", locked, 1);
    // R5 decrement and run restart
    bad("R4"); good("R5"); good("R5"); bad("R5");
    check("R5 err_cnt two", err_cnt, 2);
    for (int i = 0; i < RUN; i++) good("R5");
    check("R5 decremented", err_cnt, 1);
    for (int i = 0; i < RUN; i++) good("R5");
    check("R5 back to zero", err_cnt, 0);
    for (int i = 0; i < 2 * RUN; i++) good("R5");
    check("R5 no underflow", err_cnt, 0);
    // R6 idle while locked with errors
    bad("R6"); step(0, 10'h155, 0, 1, "R6");
    check("R6 err held", err_cnt, 1);
    // R4 loss
    bad("R4"); bad("R4");
    check("R4 lock dropped", locked, 0);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom_range(0, 99);
      logic v = (r % 10) != 0;
      if (r < 55) step(v, (r & 1) ? KPOS : KNEG, 1, 0, "R8");
      else if (r < 65) step(v, 10'($urandom), 1'($urandom), 0, "R1");
      else if (r < 72) step(v, 10'($urandom), 0, 1, "R4");
      else step(v, 10'($urandom), 0, 0, "R5");
    end
    // R7 reset mid-lock
    rst = 1; @(posedge clk); #2; rst = 0;
    m_lock = 0; m_cc = 0; m_ec = 0; m_run = 0;
    check("R7 reset locked", locked, 0);
    check("R7 reset state", state, 0);
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule